// File: doc/BRIEF.md
# Condition Code and Branch Mask Unit

This block keeps a two-bit condition code for a small integer pipeline. Signed additions (16-bit halfword or 32-bit fullword) and signed compares each produce a code. The code is registered at the clock edge that ends the operation. The code reports one of four outcomes:

- result zero or operands equal
- result negative or first operand lower
- result positive or first operand higher
- arithmetic overflow

A branch-on-condition request is evaluated combinationally against the code currently held. The request carries a four-bit mask, and each mask bit selects one code value. The mask can therefore express never, always, equal, not-equal, low, not-low, high, not-high and overflow branches.

Two branch encodings are recognised. The register form takes its target from a register value that the surrounding pipeline reads, using the index this block drives out. The indexed form takes a target address that has already been computed and is supplied with the request. The block reports whether the branch is taken and, if it is, the target.

Top module: `ccb_unit`

## Requirements
- R1: After reset, `cc_out` is 0 and `res_out` is 0.
- R2: With `op_kind` = 0 (halfword add), the low 16 bits of `op_a` and `op_b` are added modulo 2^16. `res_out` receives that 16-bit sum sign-extended to 32 bits. The code is set from the 16-bit result: 0 if zero, 1 if negative, 2 if positive, 3 if signed overflow, whatever the sign. For example, 0x6000 + 0x6000 gives 0xFFFFC000 with code 3.
- R3: With `op_kind` = 1 (fullword add), the operands are added as 32-bit two's complement. The code uses the same encoding as R2. For example, 0x6000 + 0x6000 gives 0x0000C000 with code 2 and no overflow.
- R4: With `op_kind` = 2 (compare), the code becomes 0 if `op_a` equals `op_b`, 1 if `op_a` is lower as a signed number, and 2 if it is higher. A compare never yields code 3 and leaves `res_out` unchanged.
- R5: The code and result change only at a rising edge where `op_valid` is 1 and `op_kind` is not 3. A branch requested in the same cycle as an operation uses the code from before that operation.
- R6: The mask is `br_fields[7:4]`. Bit 7 tests code 0, bit 6 tests code 1, bit 5 tests code 2 and bit 4 tests code 3. A valid request with a recognised form is taken exactly when the bit for the current code is 1. So mask 0 never branches, mask 15 always branches, 7 means not-equal, 8 equal, 11 not-low and 13 not-high.
- R7: In the register form (`br_opcode` = 0x07), `br_fields[3:0]` names the register and is driven on `br_reg_idx`. When taken, `br_target` equals `br_reg_data`.
- R8: In the register form, a register index of 0 is never taken, whatever the mask.
- R9: In the indexed form (`br_opcode` = 0x47), when taken, `br_target` equals `br_eff_addr`.
- R10: With `br_valid` low or any other opcode, the branch is not taken. `br_target` is 0 whenever the branch is not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | Operation present this cycle |
| op_kind | input | 2 | 0 halfword add, 1 fullword add, 2 compare, 3 reserved |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| res_out | output | 32 | Registered add result |
| cc_out | output | 2 | Registered condition code |
| br_valid | input | 1 | Branch request present this cycle |
| br_opcode | input | 8 | Branch opcode byte |
| br_fields | input | 8 | Mask nibble (high) and register or index nibble (low) |
| br_reg_idx | output | 4 | Register index for the register form |
| br_reg_data | input | 32 | Contents of the register named by `br_reg_idx` |
| br_eff_addr | input | 32 | Computed target address for the indexed form |
| br_taken | output | 1 | Branch taken |
| br_target | output | 32 | Branch target, 0 when not taken |

## Verification
A corrupted condition code register shows up on `cc_out` at the sample point right after the edge that wrote it. It also changes `br_taken` for any mask that separates the right code from the wrong one during the very next cycle, which is why every mask is swept against all four codes. A wrong overflow or sign flag from either adder appears one edge later as a code mismatch. A swap between the halfword and fullword datapaths is exposed by the pair of 0x6000 sums. Requests made in the same cycle as an operation expose a bypass that should not exist, because they must still see the old code.

// File: rtl/ccb_pkg.sv
package ccb_pkg;

   typedef enum logic [1:0] {
      CC_ZERO = 2'd0,
      CC_LOW  = 2'd1,
      CC_HIGH = 2'd2,
      CC_OVF  = 2'd3
   } cc_t;

   typedef enum logic [1:0] {
      OPK_ADD_HALF = 2'd0,
      OPK_ADD_FULL = 2'd1,
      OPK_CMP      = 2'd2,
      OPK_RSVD     = 2'd3
   } opk_t;

   typedef struct packed {
      logic zero;
      logic neg;
      logic ovf;
   } flags_t;

   // overflow dominates sign and zero
   function automatic cc_t cc_from_flags(flags_t f);
      if (f.ovf)       return CC_OVF;
      else if (f.zero) return CC_ZERO;
      else if (f.neg)  return CC_LOW;
      else             return CC_HIGH;
   endfunction

endpackage

// File: rtl/ccb_adder.sv
module ccb_adder
   import ccb_pkg::*;
#(
   parameter int W = 16
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic [W-1:0] sum,
   output flags_t       fl
);
   localparam int MSB = W - 1;

   always_comb begin
      sum     = a + b;
      fl.zero = (sum == '0);
      fl.neg  = sum[MSB];
      fl.ovf  = (a[MSB] == b[MSB]) && (sum[MSB] != a[MSB]);
   end

endmodule

// File: rtl/ccb_cc_reg.sv
module ccb_cc_reg
   import ccb_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int HALF_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_valid,
   input  opk_t              op_kind,
   input  logic [DATA_W-1:0] op_a,
   input  logic [DATA_W-1:0] op_b,
   input  logic [HALF_W-1:0] half_sum,
   input  flags_t            half_fl,
   input  logic [DATA_W-1:0] full_sum,
   input  flags_t            full_fl,
   output cc_t               cc_q,
   output logic [DATA_W-1:0] res_q
);
   localparam int EXT_W = DATA_W - HALF_W;

   cc_t               cc_d;
   logic [DATA_W-1:0] res_d;
   cc_t               cmp_cc;

   always_comb begin
      if ($signed(op_a) == $signed(op_b))     cmp_cc = CC_ZERO;
      else if ($signed(op_a) < $signed(op_b)) cmp_cc = CC_LOW;
      else                                    cmp_cc = CC_HIGH;
   end

   always_comb begin
      cc_d  = cc_q;
      res_d = res_q;
      if (op_valid) begin
         case (op_kind)
            OPK_ADD_HALF: begin
               cc_d  = cc_from_flags(half_fl);
               res_d = {{EXT_W{half_sum[HALF_W-1]}}, half_sum};
            end
            OPK_ADD_FULL: begin
               cc_d  = cc_from_flags(full_fl);
               res_d = full_sum;
            end
            OPK_CMP: cc_d = cmp_cc;
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cc_q  <= CC_ZERO;
         res_q <= '0;
      end else begin
         cc_q  <= cc_d;
         res_q <= res_d;
      end
   end

   a_r4_cmp_never_ovf: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_kind == OPK_CMP) |=> (cc_q != CC_OVF));

   a_r4_cmp_keeps_res: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_kind == OPK_CMP) |=> $stable(res_q));

   a_r5_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !(op_valid && op_kind != OPK_RSVD) |=> ($stable(cc_q) && $stable(res_q)));

   a_r2_half_ovf_code: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_kind == OPK_ADD_HALF && half_fl.ovf) |=> (cc_q == CC_OVF));

   a_r3_full_ovf_code: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_kind == OPK_ADD_FULL && full_fl.ovf) |=> (cc_q == CC_OVF));

endmodule

// File: rtl/ccb_branch_eval.sv
module ccb_branch_eval
   import ccb_pkg::*;
#(
   parameter int          DATA_W = 32,
   parameter int          MASK_W = 4,
   parameter int          IDX_W  = 4,
   parameter logic [7:0]  OPC_RR = 8'h07,
   parameter logic [7:0]  OPC_RX = 8'h47
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      br_valid,
   input  logic [7:0]                br_opcode,
   input  logic [MASK_W+IDX_W-1:0]   br_fields,
   input  cc_t                       cc,
   input  logic [DATA_W-1:0]         reg_data,
   input  logic [DATA_W-1:0]         eff_addr,
   output logic [IDX_W-1:0]          reg_idx,
   output logic                      taken,
   output logic [DATA_W-1:0]         target
);
   localparam int         FLD_W   = MASK_W + IDX_W;
   localparam logic [1:0] TOP_BIT = 2'(MASK_W - 1);

   generate
      if (MASK_W != 4) begin : g_bad_mask
         $error("ccb_branch_eval: mask must have one bit per code value");
      end
   endgenerate

   logic [MASK_W-1:0] mask;
   logic              is_rr, is_rx, form_ok, mask_hit;

   always_comb begin
      mask     = br_fields[FLD_W-1:IDX_W];
      reg_idx  = br_fields[IDX_W-1:0];
      is_rr    = (br_opcode == OPC_RR);
      is_rx    = (br_opcode == OPC_RX);
      form_ok  = is_rx || (is_rr && reg_idx != '0);
      // leftmost mask bit selects code 0
      mask_hit = mask[TOP_BIT - cc];
      taken    = br_valid && form_ok && mask_hit;
      if (!taken)     target = '0;
      else if (is_rr) target = reg_data;
      else            target = eff_addr;
   end

   a_r6_mask_zero_never: assert property (@(posedge clk) disable iff (!rst_n)
      (mask == '0) |-> !taken);

   a_r6_mask_full_always: assert property (@(posedge clk) disable iff (!rst_n)
      (br_valid && mask == '1 && (is_rx || (is_rr && reg_idx != '0))) |-> taken);

   a_r8_reg_zero_blocked: assert property (@(posedge clk) disable iff (!rst_n)
      (is_rr && reg_idx == '0) |-> !taken);

   a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !taken |-> (target == '0));

   a_r10_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
      taken |-> br_valid);

endmodule

// File: rtl/ccb_unit.sv
module ccb_unit
   import ccb_pkg::*;
#(
   parameter int         DATA_W = 32,
   parameter int         HALF_W = 16,
   parameter int         MASK_W = 4,
   parameter int         IDX_W  = 4,
   parameter logic [7:0] OPC_RR = 8'h07,
   parameter logic [7:0] OPC_RX = 8'h47
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    op_valid,
   input  logic [1:0]              op_kind,
   input  logic [DATA_W-1:0]       op_a,
   input  logic [DATA_W-1:0]       op_b,
   output logic [DATA_W-1:0]       res_out,
   output logic [1:0]              cc_out,
   input  logic                    br_valid,
   input  logic [7:0]              br_opcode,
   input  logic [MASK_W+IDX_W-1:0] br_fields,
   output logic [IDX_W-1:0]        br_reg_idx,
   input  logic [DATA_W-1:0]       br_reg_data,
   input  logic [DATA_W-1:0]       br_eff_addr,
   output logic                    br_taken,
   output logic [DATA_W-1:0]       br_target
);
   generate
      if (HALF_W >= DATA_W || HALF_W < 2) begin : g_bad_width
         $error("ccb_unit: halfword must be narrower than fullword");
      end
   endgenerate

   opk_t              kind;
   logic [HALF_W-1:0] half_sum;
   flags_t            half_fl;
   logic [DATA_W-1:0] full_sum;
   flags_t            full_fl;
   cc_t               cc_q;

   assign kind = opk_t'(op_kind);

   ccb_adder #(.W(HALF_W)) u_add_half (
      .a   (op_a[HALF_W-1:0]),
      .b   (op_b[HALF_W-1:0]),
      .sum (half_sum),
      .fl  (half_fl)
   );

   ccb_adder #(.W(DATA_W)) u_add_full (
      .a   (op_a),
      .b   (op_b),
      .sum (full_sum),
      .fl  (full_fl)
   );

   ccb_cc_reg #(.DATA_W(DATA_W), .HALF_W(HALF_W)) u_cc (
      .clk      (clk),
      .rst_n    (rst_n),
      .op_valid (op_valid),
      .op_kind  (kind),
      .op_a     (op_a),
      .op_b     (op_b),
      .half_sum (half_sum),
      .half_fl  (half_fl),
      .full_sum (full_sum),
      .full_fl  (full_fl),
      .cc_q     (cc_q),
      .res_q    (res_out)
   );

   assign cc_out = cc_q;

   ccb_branch_eval #(
      .DATA_W (DATA_W),
      .MASK_W (MASK_W),
      .IDX_W  (IDX_W),
      .OPC_RR (OPC_RR),
      .OPC_RX (OPC_RX)
   ) u_br (
      .clk       (clk),
      .rst_n     (rst_n),
      .br_valid  (br_valid),
      .br_opcode (br_opcode),
      .br_fields (br_fields),
      .cc        (cc_q),
      .reg_data  (br_reg_data),
      .eff_addr  (br_eff_addr),
      .reg_idx   (br_reg_idx),
      .taken     (br_taken),
      .target    (br_target)
   );

   a_r1_reset_code: assert property (@(posedge clk)
      !rst_n |-> (cc_out == 2'd0 && res_out == '0));

endmodule

// File: tb/tb_ccb_unit.sv
module tb_ccb_unit;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        op_valid = 1'b0;
   logic [1:0]  op_kind = 2'd3;
   logic [31:0] op_a = '0, op_b = '0;
   logic [31:0] res_out;
   logic [1:0]  cc_out;
   logic        br_valid = 1'b0;
   logic [7:0]  br_opcode = '0, br_fields = '0;
   logic [3:0]  br_reg_idx;
   logic [31:0] br_reg_data = '0, br_eff_addr = '0;
   logic        br_taken;
   logic [31:0] br_target;

   always #10 clk = ~clk;

   ccb_unit dut (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind),
      .op_a(op_a), .op_b(op_b), .res_out(res_out), .cc_out(cc_out),
      .br_valid(br_valid), .br_opcode(br_opcode), .br_fields(br_fields),
      .br_reg_idx(br_reg_idx), .br_reg_data(br_reg_data),
      .br_eff_addr(br_eff_addr), .br_taken(br_taken), .br_target(br_target)
   );

   typedef struct {
      int          due;
      bit          is_br;
      logic [1:0]  cc;
      logic [31:0] res;
      bit          taken;
      logic [31:0] tgt;
      logic [3:0]  idx;
      string       req;
   } item_t;

   item_t       sb_q[$];
   int          cyc = 0;
   int          checks = 0;
   int          errors = 0;
   bit          finished = 0;
   logic [1:0]  m_cc = 2'd0;
   logic [31:0] m_res = '0;

   always @(posedge clk) cyc <= cyc + 1;

   // monitor: compare each expectation in the cycle it falls due
   always @(negedge clk) begin
      while (sb_q.size() > 0 && sb_q[0].due <= cyc) begin
         item_t it;
         it = sb_q.pop_front();
         checks++;
         if (it.is_br) begin
            if (br_taken !== it.taken || br_target !== it.tgt || br_reg_idx !== it.idx) begin
               errors++;
               $display("FAIL %s: taken/target/idx got %0b/%h/%0d exp %0b/%h/%0d",
                        it.req, br_taken, br_target, br_reg_idx, it.taken, it.tgt, it.idx);
            end
         end else begin
            if (cc_out !== it.cc || res_out !== it.res) begin
               errors++;
               $display("FAIL %s: cc/res got %0d/%h exp %0d/%h",
                        it.req, cc_out, res_out, it.cc, it.res);
            end
         end
      end
   end

   // driver: one cycle of stimulus plus expectations from the requirements
   task automatic step(input bit ov, input logic [1:0] k,
                       input logic [31:0] a, input logic [31:0] b,
                       input bit bv, input logic [7:0] opc, input logic [7:0] fld,
                       input logic [31:0] rd, input logic [31:0] ea,
                       input string req);
      item_t bi, si;
      bit    legal, hit;
      @(posedge clk);
      #2;
      op_valid = ov; op_kind = k; op_a = a; op_b = b;
      br_valid = bv; br_opcode = opc; br_fields = fld;
      br_reg_data = rd; br_eff_addr = ea;
      // branch sees the code held before this cycle's operation (R5)
      legal = bv && (opc == 8'h47 || (opc == 8'h07 && fld[3:0] != 4'd0));
      hit   = fld[7 - m_cc];
      bi.due = cyc; bi.is_br = 1; bi.cc = 0; bi.res = 0;
      bi.taken = legal && hit;
      bi.tgt = !bi.taken ? 32'h0 : (opc == 8'h07 ? rd : ea);
      bi.idx = fld[3:0];
      bi.req = req;
      sb_q.push_back(bi);
      if (ov) begin
         if (k == 2'd0) begin
            logic [15:0] s16;
            int          t;
            s16 = a[15:0] + b[15:0];
            t = int'($signed(a[15:0])) + int'($signed(b[15:0]));
            m_res = {{16{s16[15]}}, s16};
            if (t > 32767 || t < -32768) m_cc = 2'd3;
            else if (s16 == 16'h0)       m_cc = 2'd0;
            else if (s16[15])            m_cc = 2'd1;
            else                         m_cc = 2'd2;
         end else if (k == 2'd1) begin
            longint t;
            t = longint'($signed(a)) + longint'($signed(b));
            m_res = a + b;
            if (t > 64'sd2147483647 || t < -64'sd2147483648) m_cc = 2'd3;
            else if (t == 0)                                 m_cc = 2'd0;
            else if (t < 0)                                  m_cc = 2'd1;
            else                                             m_cc = 2'd2;
         end else if (k == 2'd2) begin
            if ($signed(a) == $signed(b))     m_cc = 2'd0;
            else if ($signed(a) < $signed(b)) m_cc = 2'd1;
            else                              m_cc = 2'd2;
         end
      end
      si.due = cyc + 1; si.is_br = 0; si.cc = m_cc; si.res = m_res;
      si.taken = 0; si.tgt = 0; si.idx = 0; si.req = req;
      sb_q.push_back(si);
   endtask

   task automatic op(input logic [1:0] k, input logic [31:0] a, input logic [31:0] b,
                     input string req);
      step(1, k, a, b, 0, 8'h00, 8'h00, 32'h0, 32'h0, req);
   endtask

   task automatic br(input logic [7:0] opc, input logic [7:0] fld,
                     input logic [31:0] rd, input logic [31:0] ea, input string req);
      step(0, 2'd0, 32'h0, 32'h0, 1, opc, fld, rd, ea, req);
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      #4000000;
      errors++;
      $display("FAIL watchdog: run did not complete, got hang exp finish");
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;
      @(negedge clk);
      checks++;   // R1 reset state
      if (cc_out !== 2'd0 || res_out !== 32'h0) begin
         errors++;
         $display("FAIL R1: cc/res got %0d/%h exp 0/00000000", cc_out, res_out);
      end

      // R2: halfword overflow, then R3: same operands as fullword
      op(2'd0, 32'h0000_6000, 32'h0000_6000, "R2 halfword overflow");
      br(8'h47, 8'h10, 32'h0, 32'h0000_0ABC, "R6 R9 mask 1 on overflow");
      op(2'd1, 32'h0000_6000, 32'h0000_6000, "R3 fullword no overflow");
      op(2'd0, 32'h0000_0001, 32'h0000_FFFF, "R2 halfword zero");
      op(2'd0, 32'hABCD_0001, 32'h1234_FFFE, "R2 halfword negative");
      op(2'd0, 32'h0000_8000, 32'h0000_8000, "R2 negative overflow");
      op(2'd1, 32'h7FFF_FFFF, 32'h0000_0001, "R3 fullword overflow");
      op(2'd1, 32'hFFFF_FFFF, 32'hFFFF_FFFE, "R3 fullword negative");

      // R4: signed compares, including a pair whose difference overflows
      op(2'd2, 32'h0000_1234, 32'h0000_1234, "R4 compare equal");
      op(2'd2, 32'hFFFF_FFFF, 32'h0000_0001, "R4 compare low");
      op(2'd2, 32'h0000_0005, 32'hFFFF_FFF0, "R4 compare high");
      op(2'd2, 32'h8000_0000, 32'h0000_0001, "R4 compare extreme low");
      op(2'd2, 32'h7FFF_FFFF, 32'h8000_0000, "R4 compare extreme high");

      // R5: idle and reserved kind leave state alone
      step(0, 2'd0, 32'h0000_0001, 32'h0000_0001, 0, 8'h0, 8'h0, 0, 0, "R5 op_valid low");
      op(2'd3, 32'hFFFF_FFFF, 32'h0000_0001, "R5 reserved kind");

      // R5: branch in the same cycle as an op sees the old code (2 here)
      step(1, 2'd2, 32'h1, 32'h1, 1, 8'h47, 8'h80, 0, 32'h0000_1000, "R5 same-cycle old code");
      br(8'h47, 8'h80, 32'h0, 32'h0000_2000, "R5 new code next cycle");

      // R6: every mask against every code, indexed form
      for (int c = 0; c < 4; c++) begin
         case (c)
            0: op(2'd2, 32'h7, 32'h7, "R6 set code 0");
            1: op(2'd2, 32'h1, 32'h7, "R6 set code 1");
            2: op(2'd2, 32'h9, 32'h7, "R6 set code 2");
            default: op(2'd0, 32'h6000, 32'h6000, "R6 set code 3");
         endcase
         for (int m = 0; m < 16; m++)
            br(8'h47, {4'(m), 4'h3}, 32'h0, 32'h0000_4000 + 32'(m), "R6 mask sweep");
      end

      // R7: register form, target from register value
      op(2'd2, 32'h3, 32'h3, "R7 set code 0");
      br(8'h07, 8'hF5, 32'hDEAD_BEE0, 32'h1111_1111, "R7 register form always");
      br(8'h07, 8'h7A, 32'hCAFE_0000, 32'h1111_1111, "R7 register form not-equal on equal");
      br(8'h07, 8'h8A, 32'hCAFE_0010, 32'h1111_1111, "R7 register form equal");
      // R8: register 0 never branches
      br(8'h07, 8'hF0, 32'h1234_5678, 32'h1111_1111, "R8 register zero");
      br(8'h07, 8'h80, 32'h1234_5678, 32'h1111_1111, "R8 register zero mask equal");
      // R9: indexed form uses the supplied address, even with index nibble 0
      br(8'h47, 8'hF0, 32'h2222_2222, 32'h0000_0666, "R9 indexed form");
      // R10: other opcodes and no request
      br(8'h58, 8'hF5, 32'h2222_2222, 32'h3333_3333, "R10 unknown opcode");
      step(0, 2'd0, 0, 0, 0, 8'h47, 8'hF5, 32'h2222_2222, 32'h3333_3333, "R10 br_valid low");
      op(2'd1, 32'h0000_0010, 32'hFFFF_FFF0, "R3 fullword zero");
      br(8'h47, 8'h70, 32'h0, 32'h0000_0044, "R6 not-equal on zero");
      br(8'h47, 8'hB0, 32'h0, 32'h0000_0048, "R6 not-low on zero");

      step(0, 2'd0, 0, 0, 0, 8'h00, 8'h00, 0, 0, "R5 final idle");
      repeat (3) @(posedge clk);
      @(negedge clk);
      if (sb_q.size() != 0) begin
         errors++;
         $display("FAIL R5: unchecked expectations got %0d exp 0", sb_q.size());
      end
      finish_run();
   end

endmodule